// File: doc/BRIEF.md
# Integer Overflow Status Flag Generator

This block sits beside an integer ALU and keeps the fixed-point status flags the ALU's instructions report. For every operation it receives a 32-bit class code, both operands and the result the ALU produced. From these it works out whether the operation overflowed. The rule it applies depends on the operation class; no single adder rule is used. The overflow bit and a sticky summary-overflow bit are loaded on a clock edge where the update enable is high.

The same register group also holds a carry bit and a 7-bit byte-count field. The ALU's carry logic and the string-move logic write these through their own ports. The overflow and summary bits can also be written directly, for example when software restores the status register. Every flag reads back zero-extended to a 32-bit word.

An operation code outside the known set raises an error output and leaves every flag as it was.

Top module: `ovf_status_unit`

## Requirements
- R1: Add (code 0) and add-extended (code 1) produce overflow when opA and opB carry the same sign bit and bit 31 of the result differs from bit 31 of opA.
- R2: Subtract-from (code 6), subtract-from-carrying (code 7) and subtract-from-extended (code 8) apply the R1 rule with opA replaced by its bitwise inverse.
- R3: Signed divide (code 2) produces overflow when opB is zero, or when opA is 0x80000000 and opB is 0xFFFFFFFF.
- R4: Unsigned divide (code 3) produces overflow only when opB is zero.
- R5: Low multiply (code 4) produces overflow when the full signed 64-bit product of opA and opB lies outside the signed 32-bit range.
- R6: Negate (code 5) produces overflow only when opA is 0x80000000.
- R7: The summary-overflow flag is sticky. An accepted update that yields overflow sets it. Only a direct summary write clears it.
- R8: When updEn is high and opCode is not one of codes 0 to 8, opErr is high in the same cycle, and the overflow and summary flags keep their values.
- R9: On an edge where updEn is low, the overflow and summary flags change only through their direct write ports.
- R10: Direct writes of overflow, summary and carry store only bit 0 of the supplied word. A direct overflow or summary write wins over an update on the same edge.
- R11: A byte-count write stores only the low 7 bits of the supplied word.
- R12: ovOut, soOut and caOut carry their flag in bit 0 with zeros above it. bcOut carries the 7-bit field in bits 6:0 with zeros above it.
- R13: After reset all four flags read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| opCode | input | 32 | Operation class code |
| opA | input | 32 | First ALU operand |
| opB | input | 32 | Second ALU operand |
| opRes | input | 32 | Result the ALU produced |
| updEn | input | 1 | Load overflow and summary from this operation |
| ovWrEn | input | 1 | Direct overflow write strobe |
| ovWrData | input | 32 | Direct overflow write value (bit 0 used) |
| soWrEn | input | 1 | Direct summary-overflow write strobe |
| soWrData | input | 32 | Direct summary write value (bit 0 used) |
| caWrEn | input | 1 | Carry write strobe |
| caWrData | input | 32 | Carry write value (bit 0 used) |
| bcWrEn | input | 1 | Byte-count write strobe |
| bcWrData | input | 32 | Byte-count write value (bits 6:0 used) |
| ovOut | output | 32 | Overflow flag, zero-extended |
| soOut | output | 32 | Summary-overflow flag, zero-extended |
| caOut | output | 32 | Carry flag, zero-extended |
| bcOut | output | 32 | Byte count, zero-extended |
| opErr | output | 1 | Unrecognised code presented with updEn |

## Verification
The embedded assertions watch the properties that hold from one edge to the next. They check that the summary bit stays set unless it is written directly, that the overflow and summary bits hold through idle or erroneous cycles, that direct writes land on the following edge, and that the divide-by-zero cases always flag overflow. Whether each class rule gives the right answer at its boundary operands can only be shown by the bench scenarios. These include the most negative dividend divided by minus one, the product that just reaches 2^31, and sign-crossing sums and differences, each compared against a behavioural model on every clock.

// File: rtl/ovf_pkg.sv
package ovf_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned COUNT_W = 7;

  // operation class codes presented on opCode
  localparam logic [WORD_W-1:0] CODE_ADD   = 32'd0;
  localparam logic [WORD_W-1:0] CODE_ADDX  = 32'd1;
  localparam logic [WORD_W-1:0] CODE_SDIV  = 32'd2;
  localparam logic [WORD_W-1:0] CODE_UDIV  = 32'd3;
  localparam logic [WORD_W-1:0] CODE_MULLO = 32'd4;
  localparam logic [WORD_W-1:0] CODE_NEG   = 32'd5;
  localparam logic [WORD_W-1:0] CODE_SUBF  = 32'd6;
  localparam logic [WORD_W-1:0] CODE_SUBFC = 32'd7;
  localparam logic [WORD_W-1:0] CODE_SUBFX = 32'd8;

  typedef enum logic [3:0] {
    CLS_ADD, CLS_ADDX, CLS_SDIV, CLS_UDIV, CLS_MULLO,
    CLS_NEG, CLS_SUBF, CLS_SUBFC, CLS_SUBFX, CLS_NONE
  } op_class_e;

  // strobes from control to datapath
  typedef struct packed {
    op_class_e opClass;
    logic      ovLoad;   // accepted flag-updating operation
    logic      badOp;    // update requested with unknown code
    logic      ovWrite;
    logic      soWrite;
    logic      caWrite;
    logic      bcWrite;
  } flag_strobe_t;

endpackage

// File: rtl/ovf_ctrl.sv
module ovf_ctrl
  import ovf_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]  opCode,
  input  logic          updEn,
  input  logic          ovWrEn,
  input  logic          soWrEn,
  input  logic          caWrEn,
  input  logic          bcWrEn,
  output flag_strobe_t  strobes,
  output logic          opErr
);

  op_class_e decodedClass;
  logic      codeKnown;

  always_comb begin
    codeKnown = 1'b1;
    unique case (opCode)
      CODE_ADD:   decodedClass = CLS_ADD;
      CODE_ADDX:  decodedClass = CLS_ADDX;
      CODE_SDIV:  decodedClass = CLS_SDIV;
      CODE_UDIV:  decodedClass = CLS_UDIV;
      CODE_MULLO: decodedClass = CLS_MULLO;
      CODE_NEG:   decodedClass = CLS_NEG;
      CODE_SUBF:  decodedClass = CLS_SUBF;
      CODE_SUBFC: decodedClass = CLS_SUBFC;
      CODE_SUBFX: decodedClass = CLS_SUBFX;
      default: begin
        decodedClass = CLS_NONE;
        codeKnown    = 1'b0;
      end
    endcase
  end

  always_comb begin
    strobes.opClass = decodedClass;
    strobes.ovLoad  = updEn & codeKnown;
    strobes.badOp   = updEn & ~codeKnown;
    strobes.ovWrite = ovWrEn;
    strobes.soWrite = soWrEn;
    strobes.caWrite = caWrEn;
    strobes.bcWrite = bcWrEn;
  end

  assign opErr = strobes.badOp;

  // R8: an accepted load never carries the unknown class
  always_comb begin
    p_load_class_r8: assert (!(strobes.ovLoad && strobes.opClass == CLS_NONE));
  end

endmodule

// File: rtl/ovf_datapath.sv
module ovf_datapath
  import ovf_pkg::*;
#(
  parameter int unsigned W   = 32,
  parameter int unsigned BCW = 7
) (
  input  logic           clk,
  input  logic           rstN,
  input  flag_strobe_t   strobes,
  input  logic [W-1:0]   opA,
  input  logic [W-1:0]   opB,
  input  logic [W-1:0]   opRes,
  input  logic [W-1:0]   ovWrData,
  input  logic [W-1:0]   soWrData,
  input  logic [W-1:0]   caWrData,
  input  logic [W-1:0]   bcWrData,
  output logic           ovQ,
  output logic           soQ,
  output logic           caQ,
  output logic [BCW-1:0] bcQ
);

  localparam int unsigned PW = 2 * W;
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  logic [W-1:0]  invA;
  logic          addOv;
  logic          subOv;
  logic          sdivOv;
  logic          udivOv;
  logic          mulOv;
  logic          negOv;
  logic [PW-1:0] product;
  logic          ovCalc;

  assign invA = ~opA;

  // sign-agreement rules for add-like and subtract-from classes
  assign addOv = ((~(opA ^ opB)) & (opA ^ opRes)) >> (W - 1) != '0;
  assign subOv = ((~(invA ^ opB)) & (invA ^ opRes)) >> (W - 1) != '0;

  assign udivOv = (opB == '0);
  assign sdivOv = udivOv | ((opA == MOST_NEG) & (opB == ALL_ONES));
  assign negOv  = (opA == MOST_NEG);

  assign product = $signed({{W{opA[W-1]}}, opA}) * $signed({{W{opB[W-1]}}, opB});
  assign mulOv   = product[PW-1:W] != {W{product[W-1]}};

  always_comb begin
    unique case (strobes.opClass)
      CLS_ADD, CLS_ADDX:              ovCalc = addOv;
      CLS_SUBF, CLS_SUBFC, CLS_SUBFX: ovCalc = subOv;
      CLS_SDIV:                       ovCalc = sdivOv;
      CLS_UDIV:                       ovCalc = udivOv;
      CLS_MULLO:                      ovCalc = mulOv;
      CLS_NEG:                        ovCalc = negOv;
      default:                        ovCalc = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovQ <= 1'b0;
      soQ <= 1'b0;
      caQ <= 1'b0;
      bcQ <= '0;
    end else begin
      if (strobes.ovWrite)     ovQ <= ovWrData[0];
      else if (strobes.ovLoad) ovQ <= ovCalc;

      if (strobes.soWrite)                ovQ_so_write();
      else if (strobes.ovLoad && ovCalc)  soQ <= 1'b1;

      if (strobes.caWrite) caQ <= caWrData[0];
      if (strobes.bcWrite) bcQ <= bcWrData[BCW-1:0];
    end
  end

  // helper kept as a plain nonblocking write for readability
  task automatic ovQ_so_write();
    soQ <= soWrData[0];
  endtask

  // R7: summary bit stays set unless written directly
  p_so_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (soQ && !strobes.soWrite) |=> soQ);

  // R7: an accepted overflow sets the summary bit
  p_so_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ovLoad && ovCalc && !strobes.soWrite) |=> soQ);

  // R8: erroneous update leaves overflow and summary alone
  p_err_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.badOp && !strobes.ovWrite && !strobes.soWrite) |=> ($stable(ovQ) && $stable(soQ)));

  // R9: idle edge keeps the overflow bit
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.ovLoad && !strobes.ovWrite) |=> $stable(ovQ));

  // R10: direct carry write lands with bit 0 only
  p_ca_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.caWrite |=> (caQ == $past(caWrData[0])));

  // R10: direct overflow write beats a same-edge update
  p_ov_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ovWrite |=> (ovQ == $past(ovWrData[0])));

  // R11: byte-count write keeps the low field
  p_bc_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobes.bcWrite |=> (bcQ == $past(bcWrData[BCW-1:0])));

  // R3/R4: a zero divisor always raises overflow for either divide
  p_div_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ovLoad && !strobes.ovWrite && opB == '0 &&
     (strobes.opClass == CLS_UDIV || strobes.opClass == CLS_SDIV)) |=> ovQ);

endmodule

// File: rtl/ovf_status_unit.sv
module ovf_status_unit
  import ovf_pkg::*;
#(
  parameter int unsigned W   = WORD_W,
  parameter int unsigned BCW = COUNT_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] opCode,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] opRes,
  input  logic         updEn,
  input  logic         ovWrEn,
  input  logic [W-1:0] ovWrData,
  input  logic         soWrEn,
  input  logic [W-1:0] soWrData,
  input  logic         caWrEn,
  input  logic [W-1:0] caWrData,
  input  logic         bcWrEn,
  input  logic [W-1:0] bcWrData,
  output logic [W-1:0] ovOut,
  output logic [W-1:0] soOut,
  output logic [W-1:0] caOut,
  output logic [W-1:0] bcOut,
  output logic         opErr
);

  flag_strobe_t   strobes;
  logic           ovQ;
  logic           soQ;
  logic           caQ;
  logic [BCW-1:0] bcQ;

  ovf_ctrl #(.W(W)) u_ctrl (
    .opCode  (opCode),
    .updEn   (updEn),
    .ovWrEn  (ovWrEn),
    .soWrEn  (soWrEn),
    .caWrEn  (caWrEn),
    .bcWrEn  (bcWrEn),
    .strobes (strobes),
    .opErr   (opErr)
  );

  ovf_datapath #(.W(W), .BCW(BCW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .opA      (opA),
    .opB      (opB),
    .opRes    (opRes),
    .ovWrData (ovWrData),
    .soWrData (soWrData),
    .caWrData (caWrData),
    .bcWrData (bcWrData),
    .ovQ      (ovQ),
    .soQ      (soQ),
    .caQ      (caQ),
    .bcQ      (bcQ)
  );

  assign ovOut = {{(W-1){1'b0}}, ovQ};
  assign soOut = {{(W-1){1'b0}}, soQ};
  assign caOut = {{(W-1){1'b0}}, caQ};
  assign bcOut = {{(W-BCW){1'b0}}, bcQ};

endmodule

// File: tb/ovf_status_unit_bench.sv
`timescale 1ns/1ps
module ovf_status_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opCode = '0, opA = '0, opB = '0, opRes = '0;
  logic        updEn = 0, ovWrEn = 0, soWrEn = 0, caWrEn = 0, bcWrEn = 0;
  logic [31:0] ovWrData = '0, soWrData = '0, caWrData = '0, bcWrData = '0;
  logic [31:0] ovOut, soOut, caOut, bcOut;
  logic        opErr;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // behavioural model state
  int mOv = 0, mSo = 0, mCa = 0, mBc = 0;

  always #4 clk = ~clk;

  ovf_status_unit u_ovf_status_unit (
    .clk(clk), .rstN(rstN), .opCode(opCode), .opA(opA), .opB(opB), .opRes(opRes),
    .updEn(updEn), .ovWrEn(ovWrEn), .ovWrData(ovWrData), .soWrEn(soWrEn),
    .soWrData(soWrData), .caWrEn(caWrEn), .caWrData(caWrData), .bcWrEn(bcWrEn),
    .bcWrData(bcWrData), .ovOut(ovOut), .soOut(soOut), .caOut(caOut),
    .bcOut(bcOut), .opErr(opErr)
  );

  function automatic bit known(input logic [31:0] c);
    return c <= 32'd8;
  endfunction

  function automatic int refOv(input logic [31:0] c, input logic [31:0] a,
                               input logic [31:0] b, input logic [31:0] r);
    logic [31:0] na;
    longint p;
    na = ~a;
    case (c)
      0, 1: return int'((a[31] == b[31]) && (r[31] != a[31]));
      2: return int'((b == 0) || (a == 32'h8000_0000 && b == 32'hFFFF_FFFF));
      3: return int'(b == 0);
      4: begin
        p = longint'($signed(a)) * longint'($signed(b));
        return int'((p > 64'sd2147483647) || (p < -64'sd2147483648));
      end
      5: return int'(a == 32'h8000_0000);
      6, 7, 8: return int'((na[31] == b[31]) && (r[31] != na[31]));
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic clearIn();
    updEn = 0; ovWrEn = 0; soWrEn = 0; caWrEn = 0; bcWrEn = 0;
  endtask

  // inputs are already driven (after a negedge); run one clock and compare
  task automatic cycle(input string tag);
    int ov;
    #1;
    chk(tag, "opErr", opErr, (updEn && !known(opCode)) ? 1 : 0);
    ov = refOv(opCode, opA, opB, opRes);
    @(posedge clk);
    if (ovWrEn) mOv = int'(ovWrData[0]);
    else if (updEn && known(opCode)) mOv = ov;
    if (soWrEn) mSo = int'(soWrData[0]);
    else if (updEn && known(opCode) && ov == 1) mSo = 1;
    if (caWrEn) mCa = int'(caWrData[0]);
    if (bcWrEn) mBc = int'(bcWrData & 32'h7F);
    @(negedge clk);
    chk(tag, "ovOut", ovOut, mOv);
    chk(tag, "soOut", soOut, mSo);
    chk(tag, "caOut", caOut, mCa);
    chk(tag, "bcOut", bcOut, mBc);
    clearIn();
  endtask

  task automatic op(input logic [31:0] c, input logic [31:0] a, input logic [31:0] b,
                    input logic [31:0] r, input string tag);
    opCode = c; opA = a; opB = b; opRes = r; updEn = 1;
    cycle(tag);
  endtask

  task automatic clearSo();
    soWrEn = 1; soWrData = 32'h0;
    cycle("R7");
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13: reset state
    chk("R13", "ovOut", ovOut, 0);
    chk("R13", "soOut", soOut, 0);
    chk("R13", "caOut", caOut, 0);
    chk("R13", "bcOut", bcOut, 0);
    rstN = 1;
    @(negedge clk);

    // R1 add / add-extended
    op(32'd0, 32'h7FFF_FFFF, 32'h1, 32'h8000_0000, "R1");
    op(32'd0, 32'h0000_0005, 32'h3, 32'h8, "R1");
    op(32'd1, 32'h8000_0000, 32'h8000_0000, 32'h0000_0001, "R1");
    op(32'd0, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, "R1");
    clearSo();
    // R2 subtract-from family: result = b - a
    op(32'd6, 32'h1, 32'h8000_0000, 32'h7FFF_FFFF, "R2");
    op(32'd7, 32'h5, 32'h9, 32'h4, "R2");
    op(32'd8, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, "R2");
    clearSo();
    // R3 signed divide
    op(32'd2, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0, "R3");
    op(32'd2, 32'h0000_0010, 32'h0, 32'h0, "R3");
    op(32'd2, 32'h8000_0000, 32'h2, 32'hC000_0000, "R3");
    // R4 unsigned divide
    op(32'd3, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0, "R4");
    op(32'd3, 32'h1234, 32'h0, 32'h0, "R4");
    clearSo();
    // R5 low multiply
    op(32'd4, 32'h0001_0000, 32'h0001_0000, 32'h0, "R5");
    op(32'd4, 32'hFFFF_FFFF, 32'h5, 32'hFFFF_FFFB, "R5");
    op(32'd4, 32'h0000_8000, 32'h0001_0000, 32'h8000_0000, "R5");
    op(32'd4, 32'hFFFF_8000, 32'h0001_0000, 32'h8000_0000, "R5");
    // R6 negate
    op(32'd5, 32'h8000_0000, 32'h0, 32'h8000_0000, "R6");
    op(32'd5, 32'h5, 32'h0, 32'hFFFF_FFFB, "R6");
    // R7 sticky after non-overflow op, then direct clear
    op(32'd0, 32'h1, 32'h1, 32'h2, "R7");
    chk("R7", "soOut sticky", soOut, 1);
    soWrEn = 1; soWrData = 32'hFFFF_FFFE;
    cycle("R10");
    chk("R7", "soOut cleared", soOut, 0);
    // R8 unknown code with overflow-like operands
    op(32'd0, 32'h7FFF_FFFF, 32'h1, 32'h8000_0000, "R8");
    opCode = 32'h0000_0100; opA = 32'h0; opB = 32'h0; opRes = 32'h0; updEn = 1;
    cycle("R8");
    chk("R8", "ov held", ovOut, 1);
    clearSo();
    opCode = 32'h8000_0003; updEn = 1;
    cycle("R8");
    chk("R8", "so held", soOut, 0);
    // R9 no update enable
    opCode = 32'd0; opA = 32'h7FFF_FFFF; opB = 32'h1; opRes = 32'h8000_0000;
    cycle("R9");
    chk("R9", "so idle", soOut, 0);
    // R10 direct writes and priority
    caWrEn = 1; caWrData = 32'h3; cycle("R10");
    caWrEn = 1; caWrData = 32'h2; cycle("R10");
    ovWrEn = 1; ovWrData = 32'hFFFF_FFFE;
    opCode = 32'd0; opA = 32'h7FFF_FFFF; opB = 32'h1; opRes = 32'h8000_0000; updEn = 1;
    cycle("R10");
    chk("R10", "ov write wins", ovOut, 0);
    chk("R7", "so set alongside", soOut, 1);
    soWrEn = 1; soWrData = 32'h0;
    opCode = 32'd5; opA = 32'h8000_0000; updEn = 1;
    cycle("R10");
    chk("R10", "so write wins", soOut, 0);
    // R11 byte count masking, R12 zero extension
    bcWrEn = 1; bcWrData = 32'hFFFF_FFAB; cycle("R11");
    chk("R12", "bc upper zero", bcOut, 32'h2B);
    bcWrEn = 1; bcWrData = 32'h0000_0080; cycle("R11");

    // mixed random traffic, compared every clock
    for (int i = 0; i < 400; i++) begin
      int sel;
      sel = $urandom_range(0, 9);
      opCode = (sel == 9) ? 32'h0000_0040 : 32'(sel);
      opA = $urandom(); opB = ($urandom_range(0, 7) == 0) ? 32'h0 : $urandom();
      if ($urandom_range(0, 5) == 0) opA = 32'h8000_0000;
      opRes = (sel <= 1) ? opA + opB : ((sel >= 6 && sel <= 8) ? opB - opA : $urandom());
      updEn = ($urandom_range(0, 3) != 0);
      ovWrEn = ($urandom_range(0, 9) == 0); ovWrData = $urandom();
      soWrEn = ($urandom_range(0, 9) == 0); soWrData = $urandom();
      caWrEn = ($urandom_range(0, 4) == 0); caWrData = $urandom();
      bcWrEn = ($urandom_range(0, 4) == 0); bcWrData = $urandom();
      cycle("R12");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule